// File: doc/BRIEF.md
# Key-protected watchdog timer

This block is a countdown watchdog with a 32-bit register port. Software programs a timeout length, enables the countdown and then keeps it from expiring by writing a restart word. If the count runs out while the timer is enabled, the block can raise an interrupt. It can also drive a reset output, whose active level is selectable, for a fixed number of cycles. A separate register lets software request that reset pulse at once.

Each register that changes behaviour accepts a write only when the written word carries that register's own magic key. A stray or corrupted write therefore leaves the timer alone.

Time comes from a tick enable that stands in for the slow watchdog clock. A prescaler divides the ticks by 2^PRE_W (512 by default), and each prescaler wrap takes one unit off a CNT_W-bit down-counter. A status register tells software whether the most recent reset came from a timeout or from a software request.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the timer is disabled and `irq` is 0. `rst_out` is 1, because the polarity bit resets to 0 (active low). Reads return 0 from the mode register (0x00), 0x7FE0 from the length register (0x04, all-ones count), and 0 from the status register (0x0C).
- R2: A mode write (offset 0x00) is accepted only when bits 31:24 equal 0x22; otherwise it changes nothing. The mode fields are enable (bit 0), reset polarity (bit 1), reset output enable (bit 2), interrupt enable (bit 3) and dual mode (bit 6). A read returns these fields and zero everywhere else.
- R3: A length write (offset 0x04) is accepted only when bits 4:0 equal 0x08. The count sits in bits 5 upward, CNT_W bits wide. A read returns the count in the same place and zero elsewhere.
- R4: Counting starts from a load. Expiry happens on the L·2^PRE_W-th tick enable seen while enabled, where L is the programmed count (a count of 0 behaves as 1). Ticks that arrive while the timer is disabled do nothing.
- R5: Writing exactly 0x1971 to offset 0x08 reloads the counter and prescaler and clears `irq`. Any other value has no effect.
- R6: An accepted mode write that takes enable from 0 to 1 also loads the counter from the length register.
- R7: On expiry, if interrupt enable is set, `irq` rises and stays high until a restart. If reset output enable is set and dual mode is clear, the reset output is active for RST_CYC cycles, starting at the expiry edge. With dual mode set, no reset pulse is produced.
- R8: Writing exactly 0x1209 to offset 0x14 makes the reset output active from the next edge for RST_CYC cycles, whatever the enable, reset-enable or countdown state. Any other value has no effect.
- R9: `rst_out` is active high when the polarity bit is 1 and active low when it is 0.
- R10: Status bit 31 marks a timeout and bit 30 a software reset. Each new event sets its own bit and clears the other. Reading offset 0x0C clears both bits. An event that lands in the same cycle as that read is kept.
- R11: A valid restart written in the same cycle as the final tick wins: the counter reloads and no expiry happens.
- R12: After an expiry the counter stays at zero and no further expiry occurs until the next load.
- R13: Clearing enable with an accepted mode write freezes the countdown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle pulse per watchdog clock tick |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a status read clears status) |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data, including the key |
| rdata | output | 32 | Read data, valid while rd_en is high (combinational) |
| rst_out | output | 1 | Reset request, level set by the polarity bit |
| irq | output | 1 | Timeout interrupt, level |

## Verification
Two actions can fall into the same cycle. The first pair is the final tick that would expire the counter and a valid restart write. The bench drives both on one edge and expects the reload to win, with no reset pulse and no interrupt. A full new countdown must then follow.

The second pair is that same final tick and a status read. The bench holds the read strobe across the expiring edge. It expects the old value to be returned, and the timeout bit to survive the clear so that the next read shows it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   // Register offsets; software sees these, so they are fixed.
   localparam logic [7:0] OFS_MODE    = 8'h00;
   localparam logic [7:0] OFS_LEN     = 8'h04;
   localparam logic [7:0] OFS_RESTART = 8'h08;
   localparam logic [7:0] OFS_STATUS  = 8'h0C;
   localparam logic [7:0] OFS_SWRST   = 8'h14;

   // Per-register keys
   localparam logic [7:0]  KEY_MODE    = 8'h22;
   localparam logic [4:0]  KEY_LEN     = 5'h08;
   localparam logic [31:0] KEY_RESTART = 32'h0000_1971;
   localparam logic [31:0] KEY_SWRST   = 32'h0000_1209;

   localparam int LEN_LSB = 5;

   typedef struct packed {
      logic dual;
      logic irq_en;
      logic rst_en;
      logic pol;
      logic en;
   } mode_t;

   function automatic logic [31:0] mode_to_word(mode_t m);
      return {25'd0, m.dual, 2'b00, m.irq_en, m.rst_en, m.pol, m.en};
   endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int CNT_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   input  logic              expire,
   output mode_t             mode_q,
   output logic [CNT_W-1:0]  len_q,
   output logic              load,
   output logic              swrst_go,
   output logic              irq,
   output logic [31:0]       rdata
);

   localparam logic [ADDR_W-1:0] A_MODE    = ADDR_W'(OFS_MODE);
   localparam logic [ADDR_W-1:0] A_LEN     = ADDR_W'(OFS_LEN);
   localparam logic [ADDR_W-1:0] A_RESTART = ADDR_W'(OFS_RESTART);
   localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFS_STATUS);
   localparam logic [ADDR_W-1:0] A_SWRST   = ADDR_W'(OFS_SWRST);

   logic mode_wr, len_wr, restart_go, en_rise, stat_rd;
   logic tout_q, swr_q;

   // Key qualification
   always_comb begin
      mode_wr    = wr_en && (addr == A_MODE)    && (wdata[31:24] == KEY_MODE);
      len_wr     = wr_en && (addr == A_LEN)     && (wdata[4:0]   == KEY_LEN);
      restart_go = wr_en && (addr == A_RESTART) && (wdata == KEY_RESTART);
      swrst_go   = wr_en && (addr == A_SWRST)   && (wdata == KEY_SWRST);
      en_rise    = mode_wr && wdata[0] && !mode_q.en;
      load       = restart_go || en_rise;
      stat_rd    = rd_en && (addr == A_STATUS);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else if (mode_wr) begin
         mode_q.dual   <= wdata[6];
         mode_q.irq_en <= wdata[3];
         mode_q.rst_en <= wdata[2];
         mode_q.pol    <= wdata[1];
         mode_q.en     <= wdata[0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      len_q <= '1;
      else if (len_wr) len_q <= wdata[LEN_LSB +: CNT_W];
   end

   // Status: a new event wins over a read-clear; software request wins a tie.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tout_q <= 1'b0;
         swr_q  <= 1'b0;
      end else if (swrst_go) begin
         tout_q <= 1'b0;
         swr_q  <= 1'b1;
      end else if (expire) begin
         tout_q <= 1'b1;
         swr_q  <= 1'b0;
      end else if (stat_rd) begin
         tout_q <= 1'b0;
         swr_q  <= 1'b0;
      end
   end

   // Interrupt: level, cleared by a keyed restart.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      irq <= 1'b0;
      else if (restart_go)             irq <= 1'b0;
      else if (expire && mode_q.irq_en) irq <= 1'b1;
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         case (addr)
            A_MODE:   rdata = mode_to_word(mode_q);
            A_LEN:    rdata[LEN_LSB +: CNT_W] = len_q;
            A_STATUS: rdata[31:30] = {tout_q, swr_q};
            default:  rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
   parameter int CNT_W = 10,
   parameter int PRE_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] len,
   output logic             expire,
   output logic [CNT_W-1:0] cnt_q
);

   logic step, wrap, fired_q;

   assign step = run && tick && !load;

   generate
      if (PRE_W == 0) begin : g_nopre
         assign wrap = 1'b1;
      end else begin : g_pre
         logic [PRE_W-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    pre_q <= '0;
            else if (load) pre_q <= '0;
            else if (step) pre_q <= pre_q + 1'b1;
         end
         assign wrap = &pre_q;
      end
   endgenerate

   assign expire = step && wrap && !fired_q && (cnt_q <= CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               cnt_q <= '1;
      else if (load)                            cnt_q <= len;
      else if (step && wrap && (cnt_q != '0))   cnt_q <= cnt_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      fired_q <= 1'b0;
      else if (load)   fired_q <= 1'b0;
      else if (expire) fired_q <= 1'b1;
   end

endmodule

// File: rtl/wdog_rstgen.sv
module wdog_rstgen #(
   parameter int RST_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic pol,
   output logic active,
   output logic rst_out
);

   generate
      if (RST_CYC == 1) begin : g_single
         logic act_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) act_q <= 1'b0;
            else        act_q <= fire;
         end
         assign active = act_q;
      end else begin : g_multi
         localparam int RW = $clog2(RST_CYC + 1);
         logic [RW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              left_q <= '0;
            else if (fire)           left_q <= RW'(RST_CYC);
            else if (left_q != '0)   left_q <= left_q - 1'b1;
         end
         assign active = (left_q != '0);
      end
   endgenerate

   assign rst_out = pol ? active : !active;

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
   import wdog_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int CNT_W   = 10,
   parameter int PRE_W   = 9,
   parameter int RST_CYC = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic              rst_out,
   output logic              irq
);

   generate
      if (ADDR_W < 5)                     begin : g_bad_addr $error("ADDR_W must reach offset 0x14"); end
      if (CNT_W < 1 || CNT_W > 32 - LEN_LSB) begin : g_bad_cnt $error("CNT_W must fit above bit 4"); end
      if (PRE_W < 0 || PRE_W > 24)        begin : g_bad_pre  $error("PRE_W out of range"); end
      if (RST_CYC < 1)                    begin : g_bad_rst  $error("RST_CYC must be at least 1"); end
   endgenerate

   mode_t            mode_q;
   logic [CNT_W-1:0] len_q;
   logic [CNT_W-1:0] cnt_q;
   logic             load, swrst_go, expire, rst_active, fire;

   wdog_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .expire(expire), .mode_q(mode_q), .len_q(len_q),
      .load(load), .swrst_go(swrst_go), .irq(irq), .rdata(rdata)
   );

   wdog_count #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_count (
      .clk(clk), .rst_n(rst_n), .run(mode_q.en), .tick(tick_en), .load(load),
      .len(len_q), .expire(expire), .cnt_q(cnt_q)
   );

   assign fire = swrst_go || (expire && mode_q.rst_en && !mode_q.dual);

   wdog_rstgen #(.RST_CYC(RST_CYC)) u_rstgen (
      .clk(clk), .rst_n(rst_n), .fire(fire), .pol(mode_q.pol),
      .active(rst_active), .rst_out(rst_out)
   );

endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk
   import wdog_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int CNT_W  = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              tick_en,
   input logic [ADDR_W-1:0] addr,
   input logic [31:0]       wdata,
   input mode_t             mode_q,
   input logic [CNT_W-1:0]  cnt_q,
   input logic              load,
   input logic              expire,
   input logic              rst_active,
   input logic              rst_out,
   input logic              irq
);

   // R2
   mode_badkey_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFS_MODE) && wdata[31:24] != KEY_MODE) |=> $stable(mode_q));

   // R5
   restart_badval_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFS_RESTART) && wdata != KEY_RESTART && !tick_en) |=> $stable(cnt_q));

   // R8
   swrst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFS_SWRST) && wdata == KEY_SWRST) |=> rst_active);

   // R7
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(mode_q.irq_en));

   // R9
   polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_active |-> (rst_out == mode_q.pol));

   // R12
   single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !expire);

   // R13
   halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q.en && !load) |=> $stable(cnt_q));

endmodule

bind wdog_keyed wdog_keyed_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tick_en(tick_en), .addr(addr),
   .wdata(wdata), .mode_q(mode_q), .cnt_q(cnt_q), .load(load), .expire(expire),
   .rst_active(rst_active), .rst_out(rst_out), .irq(irq)
);

// File: tb/wdog_keyed_test.sv
module wdog_keyed_test;

   localparam int PRE_W = 2;
   localparam int RCYC  = 4;
   localparam int DIV   = 1 << PRE_W;

   localparam logic [7:0] A_MODE = 8'h00, A_LEN = 8'h04, A_RST = 8'h08,
                          A_STAT = 8'h0C, A_SW = 8'h14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        rst_out, irq;

   int total = 0;
   int fails = 0;

   wdog_keyed #(.ADDR_W(8), .CNT_W(10), .PRE_W(PRE_W), .RST_CYC(RCYC)) uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .rst_out(rst_out), .irq(irq)
   );

   always #2.5ns clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      rd_en = 1'b1; addr = a;
      #1ns d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic ticks(input int n);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic quiesce();
      logic [31:0] d;
      wr(A_MODE, 32'h2200_0000);
      wr(A_RST, 32'h0000_1971);
      repeat (RCYC + 1) @(negedge clk);
      rd(A_STAT, d);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(A_MODE, d); chk("R1 mode", d, 32'h0);
      rd(A_LEN, d);  chk("R1 length", d, 32'h0000_7FE0);
      rd(A_STAT, d); chk("R1 status", d, 32'h0);
      chk("R1 rst_out", {31'd0, rst_out}, 32'd1);
      chk("R1 irq", {31'd0, irq}, 32'd0);
   endtask

   task automatic t_keys();
      logic [31:0] d;
      wr(A_MODE, 32'h2100_004E);
      rd(A_MODE, d); chk("R2 bad key ignored", d, 32'h0);
      wr(A_MODE, 32'h2200_004E);
      rd(A_MODE, d); chk("R2 keyed fields", d, 32'h0000_004E);
      wr(A_MODE, 32'h2200_0000);
      wr(A_LEN, 32'h0000_00A7);
      rd(A_LEN, d); chk("R3 bad key ignored", d, 32'h0000_7FE0);
      wr(A_LEN, 32'h0000_0068);
      rd(A_LEN, d); chk("R3 keyed count", d, 32'h0000_0060);
   endtask

   task automatic t_timeout();
      logic [31:0] d;
      quiesce();
      wr(A_MODE, 32'h2200_000D);
      ticks(3 * DIV - 1);
      chk("R4 no early expiry", {30'd0, rst_out, irq}, 32'h2);
      ticks(1);
      chk("R7 reset active low", {31'd0, rst_out}, 32'd0);
      chk("R7 irq raised", {31'd0, irq}, 32'd1);
      repeat (RCYC - 1) @(negedge clk);
      chk("R7 pulse still on", {31'd0, rst_out}, 32'd0);
      @(negedge clk);
      chk("R7 pulse length", {31'd0, rst_out}, 32'd1);
      rd(A_STAT, d); chk("R10 timeout bit", d, 32'h8000_0000);
      rd(A_STAT, d); chk("R10 read clears", d, 32'h0);
      ticks(5 * DIV);
      chk("R12 no second pulse", {31'd0, rst_out}, 32'd1);
      rd(A_STAT, d); chk("R12 no second expiry", d, 32'h0);
      wr(A_RST, 32'h0000_1970);
      chk("R5 bad restart ignored", {31'd0, irq}, 32'd1);
      wr(A_RST, 32'h0000_1971);
      chk("R5 restart clears irq", {31'd0, irq}, 32'd0);
      ticks(3 * DIV - 1);
      chk("R5 reloaded, not yet", {31'd0, rst_out}, 32'd1);
      ticks(1);
      chk("R5 reloaded expiry", {31'd0, rst_out}, 32'd0);
   endtask

   task automatic t_restart_race();
      quiesce();
      wr(A_MODE, 32'h2200_000D);
      ticks(3 * DIV - 1);
      tick_en = 1'b1; wr_en = 1'b1; addr = A_RST; wdata = 32'h0000_1971;
      @(negedge clk);
      tick_en = 1'b0; wr_en = 1'b0; wdata = '0;
      chk("R11 restart wins", {30'd0, rst_out, irq}, 32'h2);
      ticks(3 * DIV - 1);
      chk("R11 full period again", {30'd0, rst_out, irq}, 32'h2);
      ticks(1);
      chk("R11 later expiry", {30'd0, rst_out, irq}, 32'h1);
   endtask

   task automatic t_status_race();
      logic [31:0] d;
      quiesce();
      wr(A_MODE, 32'h2200_000D);
      ticks(3 * DIV - 1);
      tick_en = 1'b1; rd_en = 1'b1; addr = A_STAT;
      #1ns d = rdata;
      @(negedge clk);
      tick_en = 1'b0; rd_en = 1'b0;
      chk("R10 read before event", d, 32'h0);
      rd(A_STAT, d); chk("R10 event survives clear", d, 32'h8000_0000);
   endtask

   task automatic t_dual();
      logic [31:0] d;
      quiesce();
      wr(A_MODE, 32'h2200_004D);
      ticks(3 * DIV);
      chk("R7 dual: irq only", {30'd0, rst_out, irq}, 32'h3);
      rd(A_STAT, d); chk("R10 dual timeout logged", d, 32'h8000_0000);
   endtask

   task automatic t_disable();
      quiesce();
      wr(A_MODE, 32'h2200_000D);
      ticks(2 * DIV);
      wr(A_MODE, 32'h2200_000C);
      ticks(10 * DIV);
      chk("R13 frozen while off", {30'd0, rst_out, irq}, 32'h2);
      wr(A_MODE, 32'h2200_000D);
      ticks(3 * DIV - 1);
      chk("R6 enable reloads", {30'd0, rst_out, irq}, 32'h2);
      ticks(1);
      chk("R6 expiry after reload", {30'd0, rst_out, irq}, 32'h1);
   endtask

   task automatic t_swrst();
      logic [31:0] d;
      quiesce();
      wr(A_MODE, 32'h2200_0002);
      chk("R9 high polarity idle", {31'd0, rst_out}, 32'd0);
      wr(A_SW, 32'h0000_1208);
      chk("R8 bad key no reset", {31'd0, rst_out}, 32'd0);
      wr(A_SW, 32'h0000_1209);
      chk("R8 R9 immediate active high", {31'd0, rst_out}, 32'd1);
      rd(A_STAT, d); chk("R10 software bit", d, 32'h4000_0000);
      rd(A_STAT, d); chk("R10 software bit cleared", d, 32'h0);
      repeat (RCYC) @(negedge clk);
      chk("R8 pulse ends", {31'd0, rst_out}, 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_keys();
      t_timeout();
      t_restart_race();
      t_status_race();
      t_dual();
      t_disable();
      t_swrst();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule